// File: doc/BRIEF.md
# Dual-Mode SPI Shift Controller

This block moves one byte at a time over a four-wire serial link. One shift register serves both roles. In master mode the block makes the serial clock by dividing the system clock and drives the active-low select line. In slave mode it shifts on a clock and select that arrive from outside. Those two inputs pass through two-flop synchronisers before they are used.

Software sees three things: a control word, a data register and two sticky flags. The data register is written to load a byte and read to collect the byte received. Writing it in master mode starts an exchange. In both modes a completed byte raises a done flag, and only software clears that flag. A write that lands while a byte is in flight is dropped and raises a collision flag.

Clock polarity, launch/capture edge, bit order, use of the select line and the master clock divider are all set in the control word.

Top module: `spi_dual`

## Requirements
- R1: The control word is decoded as follows: bit 0 enable, bit 1 master, bit 2 clock idle level, bit 3 edge select, bit 4 LSB-first, bit 5 select-line use, bits 7:6 divider code. While enable is 0, no output enable is asserted, a data write starts no transfer, and done stays 0.
- R2: In master mode with enable set, a data write pulls the select output low on the following clock. It then produces 8 clock pulses, 16 edges in all. One bit goes out on the serial output per pulse while one serial input bit is captured. At the end the data register holds the received byte.
- R3: The done flag is set when a byte completes. It stays at 1 until the done-clear input is pulsed.
- R4: When no transfer is active, the serial clock output sits at the level of the idle-level bit.
- R5: With edge select 0, a bit is presented before the leading (first) clock edge, captured on the leading edge and replaced on the trailing edge. With edge select 1, a bit is launched on the leading edge and captured on the trailing edge. This holds in all four combinations with the idle level.
- R6: With LSB-first 0, bit 7 goes out first and the first received bit ends in bit 7. With LSB-first 1, bit 0 goes out first and the first received bit ends in bit 0.
- R7: The master clock period is 4, 16, 64 or 256 system clocks for divider codes 0, 1, 2 and 3.
- R8: With select-line use 0, the select output enable stays low and master transfers run unchanged. In slave mode the select input is ignored and the block behaves as always selected.
- R9: In slave mode, external clock edges shift the data register out and shift the serial input in. Done rises only after the 16th edge.
- R10: In slave mode with select-line use set, the serial output is enabled only while select is low. With edge select 0, the first bit appears as soon as select goes low and holds until the first edge.
- R11: A slave deselected in mid-byte aborts. The serial output is released, done is not set, and the next byte counts its edges from zero.
- R12: A data write during an active transfer does not alter the register or the serial output. It sets the collision flag, which stays set until the collision-clear input is pulsed.
- R13: In master mode the select output is low for one full half period before the first clock edge. It stays low through the last edge and returns high when done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | W | Byte to load |
| data_rdata | output | W | Data register contents |
| done_clr | input | 1 | Clears the done flag |
| done | output | 1 | Byte-complete flag |
| wcol_clr | input | 1 | Clears the collision flag |
| wcol | output | 1 | Write-collision flag |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| csn_i | input | 1 | Active-low select from an external master |
| csn_o | output | 1 | Generated active-low select |
| csn_oe | output | 1 | Select output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The bench builds the block with the default width of 8 bits, so one byte takes 16 edges. With that width, all four divider codes finish within a few thousand cycles, so the 256-cycle period is measured directly rather than inferred. The default also keeps the edge counter short enough that a mid-byte abort followed by a full byte shows whether the counter restarts, since any leftover count would raise done early.

// File: rtl/spi_dual.sv
module spi_dual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wdata,
  input  logic         data_we,
  input  logic [W-1:0] data_wdata,
  output logic [W-1:0] data_rdata,
  input  logic         done_clr,
  output logic         done,
  input  logic         wcol_clr,
  output logic         wcol,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         csn_i,
  output logic         csn_o,
  output logic         csn_oe,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe
);
  localparam int EDGES = 2 * W;
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES);
  localparam logic [CW-1:0] PENULT = CW'(EDGES - 1);

  logic [7:0]    ctrl_q;
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;
  logic [7:0]    div_cnt;
  logic          busy, sck_q, sdo_q;
  logic [2:0]    sck_s, csn_s;

  logic en, master, cpol, cpha, lsbf, cs_en;
  logic [1:0] dv;
  assign {dv, cs_en, lsbf, cpha, cpol, master, en} = ctrl_q;

  function automatic logic outbit(input logic [W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[W-1];
  endfunction

  logic [7:0] half_m1;
  logic sel, sel_rise, sel_fall, s_act, tick, edge_ev, lead, cap, launch, inprog, start, byte_end;
  logic [W-1:0] shifted;

  assign half_m1  = (8'd2 << {dv, 1'b0}) - 8'd1;
  assign sel      = cs_en ? ~csn_s[1] : 1'b1;
  assign sel_rise = cs_en & ~csn_s[1] & csn_s[2];
  assign sel_fall = cs_en & csn_s[1] & ~csn_s[2];
  assign s_act    = en & ~master & sel;
  assign tick     = busy && div_cnt == 8'd0;
  assign edge_ev  = master ? (tick && cnt != LAST) : (s_act && (sck_s[1] ^ sck_s[2]));
  assign lead     = ~cnt[0];
  assign cap      = edge_ev & (lead ^ cpha);
  assign launch   = edge_ev & ~(lead ^ cpha);
  assign inprog   = busy | (s_act && cnt != '0);
  assign start    = en & master & data_we & ~busy;
  assign shifted  = lsbf ? {sdi, sreg[W-1:1]} : {sreg[W-2:0], sdi};
  assign byte_end = ~ctrl_we & (master ? (tick && cnt == LAST) : (edge_ev && cnt == PENULT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sreg    <= '0;
      cnt     <= '0;
      div_cnt <= '0;
      busy    <= 1'b0;
      sck_q   <= 1'b0;
      sdo_q   <= 1'b0;
      sck_s   <= '0;
      csn_s   <= '1;
      done    <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      csn_s <= {csn_s[1:0], csn_i};

      if (ctrl_we) begin
        ctrl_q <= ctrl_wdata;
        busy   <= 1'b0;
        cnt    <= '0;
        sck_q  <= ctrl_wdata[2];
      end else if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        div_cnt <= half_m1;
        sck_q   <= cpol;
      end else if (busy) begin
        if (div_cnt != 8'd0) div_cnt <= div_cnt - 8'd1;
        else begin
          div_cnt <= half_m1;
          if (cnt == LAST) busy <= 1'b0;
          else begin
            sck_q <= ~sck_q;
            cnt   <= cnt + CW'(1);
          end
        end
      end else if (!master) begin
        if (sel_rise || sel_fall) cnt <= '0;
        else if (edge_ev) cnt <= (cnt == PENULT) ? '0 : cnt + CW'(1);
      end

      if (data_we && !inprog) begin
        sreg  <= data_wdata;
        sdo_q <= outbit(data_wdata, lsbf);
      end else if (cap) sreg <= shifted;
      else if (launch) sdo_q <= outbit(sreg, lsbf);
      else if (sel_rise && !cpha) sdo_q <= outbit(sreg, lsbf);

      if (byte_end) done <= 1'b1;
      else if (done_clr) done <= 1'b0;

      if (data_we && inprog) wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;
    end
  end

  assign data_rdata = sreg;
  assign sck_o  = busy ? sck_q : cpol;
  assign sck_oe = en & master;
  assign csn_o  = ~busy;
  assign csn_oe = en & master & cs_en;
  assign sdo    = sdo_q;
  assign sdo_oe = en & (master | sel);

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
  assert_cs_first_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && cs_en && !$past(ctrl_we) && sck_o != $past(sck_o)) |-> (!csn_o && !$past(csn_o)));
  assert_wcol_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && busy) |=> wcol);
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !master && cs_en && !ctrl_we && $rose(csn_s[1])) |=> cnt == '0);
endmodule

// File: tb/sim_spi_dual.sv
module sim_spi_dual;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0, done_clr = 1'b0, wcol_clr = 1'b0;
  logic [7:0] ctrl_wdata = '0, data_wdata = '0;
  logic sck_i = 1'b0, csn_i = 1'b1, sdi = 1'b0;
  logic [7:0] data_rdata;
  logic done, wcol, sck_o, sck_oe, csn_o, csn_oe, sdo, sdo_oe;
  int n_chk = 0, n_fail = 0, cyc = 0;

  spi_dual #(.W(8)) u0 (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic bsel(input logic [7:0] v, input int i, input logic lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  function automatic logic [7:0] seq_of(input logic [7:0] v, input logic lsb);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = bsel(v, i, lsb);
    return s;
  endfunction

  function automatic logic [7:0] cw(input logic e, m, pol, ph, lsb, cs, input logic [1:0] dv);
    return {dv, cs, lsb, ph, pol, m, e};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic [7:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic m_xfer(input logic [7:0] tx, rxb, input logic pol, ph, lsb, cs, input logic [1:0] dv);
    int edges, t0, t2, ts, guard, li, h;
    logic prev;
    logic [7:0] seq;
    h = 2 << (2 * dv);
    set_ctrl(cw(1'b1, 1'b1, pol, ph, lsb, cs, dv));
    chk(sck_o == pol, "R4 idle level", sck_o, pol);
    wr(tx);
    ts = cyc;
    chk(csn_o == 1'b0, "R2 select low after write", csn_o, 0);
    chk(csn_oe == cs, "R8 select drive", csn_oe, cs);
    if (!ph) sdi = bsel(rxb, 0, lsb);
    prev = pol; edges = 0; guard = 0; seq = '0; t0 = 0; t2 = 0;
    while (!done && guard < 3000) begin
      if (sck_o !== prev) begin
        edges++;
        prev = sck_o;
        if (edges % 2 == 1) begin
          li = (edges - 1) / 2;
          if (li < 8) seq[li] = sdo;
          if (edges == 1) begin
            t0 = cyc;
            chk(csn_o == 1'b0, "R13 select low at first edge", csn_o, 0);
          end
          if (edges == 3) t2 = cyc;
          if (ph && li < 8) sdi = bsel(rxb, li, lsb);
        end else if (!ph && edges / 2 < 8) sdi = bsel(rxb, edges / 2, lsb);
      end
      @(negedge clk);
      guard++;
    end
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(seq == seq_of(tx, lsb), "R2 R5 R6 serial out", seq, seq_of(tx, lsb));
    chk(data_rdata == rxb, "R2 R5 R6 received byte", data_rdata, rxb);
    chk(t2 - t0 == 2 * h, "R7 clock period", t2 - t0, 2 * h);
    chk(t0 - ts == h, "R13 setup before first edge", t0 - ts, h);
    chk(csn_o == 1'b1, "R13 select released", csn_o, 1);
    chk(sck_o == pol, "R4 idle after byte", sck_o, pol);
    chk(done == 1'b1, "R3 done set", done, 1);
    wait_n(20);
    chk(done == 1'b1, "R3 done sticky", done, 1);
    clr_done();
    chk(done == 1'b0, "R3 done cleared", done, 0);
  endtask

  task automatic s_xfer(input logic [7:0] tx, rxb, input logic pol, ph, lsb, cs, cfg);
    logic [7:0] seq;
    seq = '0;
    if (cfg) begin
      sck_i = pol; csn_i = 1'b1;
      wait_n(6);
      set_ctrl(cw(1'b1, 1'b0, pol, ph, lsb, cs, 2'd0));
    end
    wr(tx);
    if (cs) begin
      chk(sdo_oe == 1'b0, "R10 released while deselected", sdo_oe, 0);
      csn_i = 1'b0;
    end else chk(sdo_oe == 1'b1, "R8 slave always selected", sdo_oe, 1);
    if (!ph) sdi = bsel(rxb, 0, lsb);
    wait_n(6);
    chk(sdo_oe == 1'b1, "R9 output driven when selected", sdo_oe, 1);
    if (!ph) chk(sdo == bsel(tx, 0, lsb), "R10 first bit before edge", sdo, bsel(tx, 0, lsb));
    for (int i = 0; i < 8; i++) begin
      if (!ph) seq[i] = sdo;
      sck_i = ~pol;
      if (ph) sdi = bsel(rxb, i, lsb);
      wait_n(8);
      if (ph) seq[i] = sdo;
      sck_i = pol;
      if (!ph && i < 7) sdi = bsel(rxb, i + 1, lsb);
      wait_n(8);
      if (i == 6) chk(done == 1'b0, "R9 R11 no early done", done, 0);
    end
    wait_n(4);
    chk(done == 1'b1, "R9 slave done", done, 1);
    chk(data_rdata == rxb, "R9 R6 slave received", data_rdata, rxb);
    chk(seq == seq_of(tx, lsb), "R5 R9 slave serial out", seq, seq_of(tx, lsb));
    if (cs) begin
      csn_i = 1'b1;
      wait_n(6);
      chk(sdo_oe == 1'b0, "R10 released after deselect", sdo_oe, 0);
    end
    clr_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] a, b;
    logic p, q, l;
    void'($urandom(32'd1234));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk(done == 1'b0, "R3 reset done", done, 0);
    chk(wcol == 1'b0, "R12 reset wcol", wcol, 0);
    chk(sck_oe == 1'b0 && sdo_oe == 1'b0 && csn_oe == 1'b0, "R1 reset enables", sdo_oe, 0);

    set_ctrl(cw(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0));
    wr(8'h3C);
    wait_n(40);
    chk(done == 1'b0, "R1 no transfer when off", done, 0);
    chk(sck_oe == 1'b0, "R1 clock not driven", sck_oe, 0);
    chk(csn_oe == 1'b0, "R1 select not driven", csn_oe, 0);
    chk(sdo_oe == 1'b0, "R1 data not driven", sdo_oe, 0);

    for (int k = 0; k < 12; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      p = 1'($urandom); q = 1'($urandom); l = 1'($urandom);
      m_xfer(a, b, p, q, l, 1'b1, 2'($urandom % 2));
    end
    m_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2);
    m_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
    m_xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);

    for (int m = 0; m < 4; m++) begin
      a = 8'($urandom); b = 8'($urandom); l = 1'($urandom);
      s_xfer(a, b, m[1], m[0], l, 1'b1, 1'b1);
    end

    sck_i = 1'b0; csn_i = 1'b1;
    wait_n(6);
    set_ctrl(cw(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0));
    wr(8'hA5);
    csn_i = 1'b0;
    wait_n(6);
    for (int i = 0; i < 3; i++) begin
      sck_i = 1'b1; wait_n(8);
      sck_i = 1'b0; wait_n(8);
    end
    csn_i = 1'b1;
    wait_n(6);
    chk(sdo_oe == 1'b0, "R11 output released on abort", sdo_oe, 0);
    chk(done == 1'b0, "R11 no done on abort", done, 0);
    s_xfer(8'h96, 8'h1E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    s_xfer(8'hC5, 8'h2B, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

    set_ctrl(cw(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3));
    sdi = 1'b1;
    wr(8'h80);
    wait_n(4);
    wr(8'h00);
    chk(wcol == 1'b1, "R12 collision flag", wcol, 1);
    chk(sdo == 1'b1, "R12 output unchanged", sdo, 1);
    chk(data_rdata == 8'h80, "R12 register unchanged", data_rdata, 8'h80);
    for (int g = 0; g < 3000 && !done; g++) @(negedge clk);
    chk(done == 1'b1, "R12 transfer completes", done, 1);
    chk(data_rdata == 8'hFF, "R12 received byte", data_rdata, 8'hFF);
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk(wcol == 1'b0, "R12 collision cleared", wcol, 0);
    clr_done();

    report();
  end
endmodule